// File: doc/BRIEF.md
# Serial Audio Output Port

This block sends decoded audio samples out as a bit-serial stream. It drives three signals: a bit clock, a frame-sync that marks the left and right halves of each stereo frame, and one data line. Every sample occupies a 32-bit slot, so a stereo frame lasts 64 bit periods. Samples are sent MSB first and left-justified, and the bits below the sample width are zero.

In master mode the port builds its own timing from the system clock, which runs at 256 times the sample rate. The bit clock is that clock divided by four. In slave mode the bit clock and frame-sync come in from outside. They are synchronised into the system clock domain, and their output enables stay low. A launch-edge control picks which bit-clock edge moves the data line.

Samples arrive one word at a time, each tagged with its channel. They wait in a per-channel holding register until their slot starts. At each slot load the block chooses what to send:
- When repeat-on-error is enabled and the receiver has lost lock, it sends silence.
- When repeat-on-error is enabled and the error flag is raised, it sends the word last sent on that channel again.
- Otherwise it sends the newest word.

Top module: `audio_serial_tx`

## Requirements
- R1: With `run` and `master` high, `bclk_out` has a period of exactly 4 `clk` cycles and is high for half of it. Its first rising edge comes on the second `clk` edge after `run` is sampled high. `bclk_oe` and `fsync_oe` are high in this state.
- R2: In master mode each slot lasts exactly 32 bit periods. The first slot after start is the left slot, with `fsync_out` = 1. Slots then alternate left (`fsync_out` = 1) and right (`fsync_out` = 0), and `fsync_out` changes only on a launch edge.
- R3: With `run` high and `master` low, the port times its slots from `bclk_in` and `fsync_in`, and `bclk_oe` and `fsync_oe` stay low. A change of `fsync_in`, seen at a launch edge, starts a slot. The slot is left when `fsync_in` = 1 and right when it is 0.
- R4: With `fall_launch` = 1, `sdata` changes only together with a falling bit-clock edge and is captured on the rising edge. With `fall_launch` = 0 the two edges swap roles.
- R5: A slot carries its sample MSB first in bit periods 0 to SAMPLE_W-1. The remaining 32-SAMPLE_W bit periods carry 0.
- R6: When `repeat_on_err` = 1, `locked` = 1 and `err_flag` = 1 at a slot load, the slot sends again the word last sent on the same channel.
- R7: When `repeat_on_err` = 1 and `locked` = 0 at a slot load, the slot sends all zeros, whatever the state of `err_flag`.
- R8: When `repeat_on_err` = 0, neither `err_flag` nor `locked` has any effect, and each slot sends the newest word written for its channel.
- R9: A word presented with `in_valid` = 1 is stored for the channel given by `in_right` (0 = left, 1 = right). A word written while a slot is shifting does not change that slot. It is sent in the next slot of its channel.
- R10: While `run` is low, `sdata`, `bclk_out` and `fsync_out` are 0, both output enables are 0, and the stored last-sent words are cleared to zero. The holding registers keep their contents and accept writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Port enable; low holds the port idle with its clock pins released |
| master | input | 1 | 1: port drives bit clock and frame-sync; 0: takes them as inputs |
| fall_launch | input | 1 | 1: data moves on falling bit-clock edge; 0: on rising edge |
| repeat_on_err | input | 1 | Enables repeat-on-error and mute-while-unlocked |
| in_data | input | SAMPLE_W | Received sample word |
| in_valid | input | 1 | Strobe: store `in_data` this cycle |
| in_right | input | 1 | Channel of `in_data`: 0 left, 1 right |
| err_flag | input | 1 | Receiver error flag |
| locked | input | 1 | Receiver lock status |
| bclk_in | input | 1 | External bit clock (slave mode) |
| fsync_in | input | 1 | External frame-sync (slave mode) |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Output enable for the bit-clock pin |
| fsync_out | output | 1 | Generated frame-sync, 1 for the left slot |
| fsync_oe | output | 1 | Output enable for the frame-sync pin |
| sdata | output | 1 | Serial audio data |

## Verification
Error handling and loss of lock can both be active at the same slot load. The bench sets up that case by raising the error flag and dropping lock together with repeat enabled. It then checks that the reconstructed slot is all zeros rather than the repeated word. Error handling also has to work together with the holding of samples. In every slot the bench writes a decoy word into the channel being shifted, in the middle of the slot. The word read back from the pins must still match the sample that was loaded at the slot boundary, in all four combinations of mode and launch edge.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef enum logic [1:0] {
    SRC_FRESH  = 2'd0,
    SRC_REPEAT = 2'd1,
    SRC_MUTE   = 2'd2
  } src_e;

  // Lost lock outranks the error flag; both matter only with repeat enabled.
  function automatic src_e pick_source(input logic rep, input logic err, input logic lock);
    if (rep && !lock) return SRC_MUTE;
    if (rep && err) return SRC_REPEAT;
    return SRC_FRESH;
  endfunction

endpackage

// File: rtl/atx_master_clk.sv
module atx_master_clk #(
  parameter int DIV    = 4,
  parameter int SLOT_W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fall_launch,
  output logic bclk,
  output logic fsync,
  output logic launch,
  output logic slot_start,
  output logic slot_right
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam int PW   = $clog2(2 * SLOT_W);

  logic [CW-1:0] cnt, cnt_n;
  logic [PW-1:0] pos, pos_n;
  logic          bclk_r, fs_r;

  always_comb begin
    cnt_n      = (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
    pos_n      = pos + 1'b1;
    launch     = en && (cnt == (fall_launch ? CW'(DIV - 1) : CW'(HALF - 1)));
    slot_start = launch && (pos_n[PW-2:0] == '0);
    slot_right = pos_n[PW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pos    <= '1;
      bclk_r <= 1'b0;
      fs_r   <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      pos    <= '1;
      bclk_r <= 1'b0;
      fs_r   <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      bclk_r <= (cnt_n >= CW'(HALF));
      if (launch) begin
        pos  <= pos_n;
        fs_r <= ~pos_n[PW-1];
      end
    end
  end

  assign bclk  = bclk_r;
  assign fsync = fs_r;

  AST_FS_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n || !en)
    !$stable(fs_r) |-> $past(launch)); // R2
  AST_BCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $rose(bclk_r) |=> bclk_r); // R1

endmodule

// File: rtl/atx_slave_sync.sv
module atx_slave_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fall_launch,
  input  logic bclk_in,
  input  logic fsync_in,
  output logic launch,
  output logic slot_start,
  output logic slot_right
);
  logic [STAGES-1:0] b_sync, f_sync;
  logic              b_now, b_old, f_now, f_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_sync <= '0;
      f_sync <= '0;
      b_old  <= 1'b0;
    end else begin
      b_sync <= {b_sync[STAGES-2:0], bclk_in};
      f_sync <= {f_sync[STAGES-2:0], fsync_in};
      b_old  <= b_now;
    end
  end

  assign b_now = b_sync[STAGES-1];
  assign f_now = f_sync[STAGES-1];

  always_comb begin
    launch     = en && (b_now != b_old) && (b_now == ~fall_launch);
    slot_start = launch && (f_now != f_seen);
    slot_right = ~f_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      f_seen <= 1'b0;
    else if (!en)    f_seen <= 1'b0;
    else if (launch) f_seen <= f_now;
  end

  AST_SLAVE_LAUNCH_EDGE: assert property (@(posedge clk) disable iff (!rst_n || !en)
    launch |-> (b_sync[STAGES-1] != $past(b_sync[STAGES-1]))); // R3

endmodule

// File: rtl/atx_word_sel.sv
module atx_word_sel
  import audio_tx_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  input  logic         in_right,
  input  logic         slot_start,
  input  logic         slot_right,
  input  logic         rep,
  input  logic         err,
  input  logic         locked,
  output logic [W-1:0] word
);
  logic [W-1:0] stage_q [2];
  logic [W-1:0] last_q  [2];
  src_e         src;

  always_comb begin
    src = pick_source(rep, err, locked);
    unique case (src)
      SRC_MUTE:   word = '0;
      SRC_REPEAT: word = last_q[slot_right];
      default:    word = stage_q[slot_right];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q[0] <= '0;
      stage_q[1] <= '0;
    end else if (in_valid) begin
      stage_q[in_right] <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q[0] <= '0;
      last_q[1] <= '0;
    end else if (!run) begin
      last_q[0] <= '0;
      last_q[1] <= '0;
    end else if (slot_start) begin
      last_q[slot_right] <= word;
    end
  end

  AST_REPEAT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    run && slot_start && !slot_right && rep && err && locked |=> $stable(last_q[0])); // R6
  AST_REPEAT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    run && slot_start && slot_right && rep && err && locked |=> $stable(last_q[1])); // R6
  AST_FRESH_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    run && slot_start && !slot_right && !rep && !in_valid |=> last_q[0] == stage_q[0]); // R8

endmodule

// File: rtl/atx_shifter.sv
module atx_shifter #(
  parameter int W      = 24,
  parameter int SLOT_W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         launch,
  input  logic         slot_start,
  input  logic [W-1:0] word,
  output logic         sdata
);
  logic [SLOT_W-1:0] shreg, loaded;

  generate
    if (SLOT_W > W) begin : g_pad
      assign loaded = {word, {(SLOT_W - W){1'b0}}};
    end else begin : g_full
      assign loaded = word[W-1 -: SLOT_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          shreg <= '0;
    else if (!run)       shreg <= '0;
    else if (slot_start) shreg <= loaded;
    else if (launch)     shreg <= {shreg[SLOT_W-2:0], 1'b0};
  end

  assign sdata = shreg[SLOT_W-1];

  AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n || !run)
    !launch |=> $stable(sdata)); // R4

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx #(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_W      = 32,
  parameter int MCLK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                master,
  input  logic                fall_launch,
  input  logic                repeat_on_err,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_valid,
  input  logic                in_right,
  input  logic                err_flag,
  input  logic                locked,
  input  logic                bclk_in,
  input  logic                fsync_in,
  output logic                bclk_out,
  output logic                bclk_oe,
  output logic                fsync_out,
  output logic                fsync_oe,
  output logic                sdata
);
  logic master_en, slave_en;
  logic m_launch, m_start, m_right;
  logic s_launch, s_start, s_right;
  logic launch, slot_start, slot_right;
  logic [SAMPLE_W-1:0] word;

  assign master_en = run & master;
  assign slave_en  = run & ~master;

  atx_master_clk #(.DIV(MCLK_DIV), .SLOT_W(SLOT_W)) u_mclk (
    .clk(clk), .rst_n(rst_n), .en(master_en), .fall_launch(fall_launch),
    .bclk(bclk_out), .fsync(fsync_out), .launch(m_launch),
    .slot_start(m_start), .slot_right(m_right)
  );

  atx_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(slave_en), .fall_launch(fall_launch),
    .bclk_in(bclk_in), .fsync_in(fsync_in), .launch(s_launch),
    .slot_start(s_start), .slot_right(s_right)
  );

  always_comb begin
    launch     = master ? m_launch : s_launch;
    slot_start = master ? m_start  : s_start;
    slot_right = master ? m_right  : s_right;
  end

  atx_word_sel #(.W(SAMPLE_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .run(run), .in_data(in_data), .in_valid(in_valid),
    .in_right(in_right), .slot_start(slot_start), .slot_right(slot_right),
    .rep(repeat_on_err), .err(err_flag), .locked(locked), .word(word)
  );

  atx_shifter #(.W(SAMPLE_W), .SLOT_W(SLOT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .run(run), .launch(launch),
    .slot_start(slot_start), .word(word), .sdata(sdata)
  );

  assign bclk_oe  = master_en;
  assign fsync_oe = master_en;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sdata && !bclk_out && !fsync_out)); // R10
  AST_MUTE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    run && slot_start && repeat_on_err && !locked |=> !sdata); // R7
  AST_LAUNCH_EDGE: assert property (@(posedge clk) disable iff (!rst_n || !run || !master)
    !$stable(sdata) |-> (fall_launch ? $fell(bclk_out) : $rose(bclk_out))); // R4

endmodule

// File: tb/audio_serial_tx_bench.sv
module audio_serial_tx_bench;
  localparam int W     = 24;
  localparam int SLOT  = 32;
  localparam int NSLOT = 22;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, run, master, fall_launch, repeat_on_err, in_valid, in_right;
  logic err_flag, locked, bclk_in, fsync_in;
  logic [W-1:0] in_data;
  logic bclk_out, bclk_oe, fsync_out, fsync_oe, sdata;

  audio_serial_tx #(.SAMPLE_W(W), .SLOT_W(SLOT)) u_audio_serial_tx (
    .clk(clk), .rst_n(rst_n), .run(run), .master(master), .fall_launch(fall_launch),
    .repeat_on_err(repeat_on_err), .in_data(in_data), .in_valid(in_valid),
    .in_right(in_right), .err_flag(err_flag), .locked(locked), .bclk_in(bclk_in),
    .fsync_in(fsync_in), .bclk_out(bclk_out), .bclk_oe(bclk_oe), .fsync_out(fsync_out),
    .fsync_oe(fsync_oe), .sdata(sdata)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] dval(input int s);
    logic [31:0] t = 32'(s) * 32'h009E_3779 + 32'h0005_A5A5;
    return t[W-1:0];
  endfunction

  // {rep, err, lock} applied to slot s
  function automatic logic [2:0] sched(input int s);
    case (s % 10)
      0: return 3'b111;
      1: return 3'b001;
      2: return 3'b101;
      3: return 3'b111;
      4: return 3'b111;
      5: return 3'b011;
      6: return 3'b100;
      7: return 3'b110;
      8: return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  function automatic string tag(input int s);
    case (s % 10)
      0: return "R10";
      1, 2: return "R5/R9";
      3, 4, 9: return "R6";
      5, 8: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic apply_sched(input int s);
    logic [2:0] c = sched(s);
    repeat_on_err = c[2];
    err_flag      = c[1];
    locked        = c[0];
  endtask

  task automatic run_config(input bit ms, input bit fl);
    logic [W-1:0] stagedm [2];
    logic [W-1:0] lastm [2];
    logic [W-1:0] exp_cur;
    logic [31:0]  acc;
    string        tag_cur;
    logic b, f, d, bprev, dprev, fcap;
    bit   started;
    int   nbits, slotidx, compared, cyc, first_rise, rise_last;
    int   per_err, edge_err, oe_err, wphase, mid_s, ph, sb;
    int   curch;

    run = 1'b0; master = ms; fall_launch = fl; in_valid = 1'b0;
    bclk_in = fl; fsync_in = 1'b0;
    repeat (4) @(negedge clk);
    check(!bclk_oe && !fsync_oe, "R10", "oe while idle", {bclk_oe, fsync_oe}, 0);
    check(!sdata && !bclk_out && !fsync_out, "R10", "pins while idle",
          {sdata, bclk_out, fsync_out}, 0);

    in_valid = 1'b1; in_right = 1'b0; in_data = dval(0);
    @(negedge clk);
    in_right = 1'b1; in_data = dval(1);
    @(negedge clk);
    in_valid = 1'b0;
    stagedm[0] = dval(0); stagedm[1] = dval(1);
    lastm[0] = '0; lastm[1] = '0;
    apply_sched(0);
    @(negedge clk);
    check(!sdata, "R10", "sdata after idle writes", sdata, 0);

    bprev = ms ? bclk_out : bclk_in; dprev = sdata; fcap = 1'b0; started = 1'b0;
    nbits = 0; slotidx = -1; compared = 0; cyc = 0; first_rise = -1; rise_last = 0;
    per_err = 0; edge_err = 0; oe_err = 0; wphase = 0; mid_s = 0; ph = 0; sb = 0;
    acc = '0; exp_cur = '0; tag_cur = ""; curch = 0;
    run = 1'b1;

    while (compared < NSLOT && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      b = ms ? bclk_out : bclk_in;
      f = ms ? fsync_out : fsync_in;
      d = sdata;
      if (ms) begin
        if (!bclk_oe || !fsync_oe) oe_err++;
        if (b && !bprev) begin
          if (first_rise < 0) first_rise = cyc;
          else if (cyc - rise_last != 4) per_err++;
          rise_last = cyc;
        end
        if (d != dprev && !(b != bprev && b == !fl)) edge_err++;
      end else if (bclk_oe || fsync_oe) oe_err++;

      if (wphase == 1) begin
        in_right = ~curch[0];
        in_data = dval(mid_s + 1);
        stagedm[~curch[0]] = dval(mid_s + 1);
        wphase = 2;
      end else if (wphase == 2) begin
        in_valid = 1'b0;
        wphase = 0;
      end

      if (b != bprev && b == fl) begin
        if (f != fcap) begin
          if (started) begin
            check(nbits == SLOT, ms ? "R2" : "R3", "bits in slot", nbits, SLOT);
            check(acc == {exp_cur, {(SLOT - W){1'b0}}}, tag_cur, "slot word",
                  acc, {exp_cur, {(SLOT - W){1'b0}}});
            compared++;
          end
          started = 1'b1;
          slotidx++;
          nbits = 0;
          acc = '0;
          fcap = f;
          curch = f ? 0 : 1;
          check(f == (slotidx % 2 == 0), ms ? "R2" : "R3", "slot channel order", f,
                (slotidx % 2 == 0));
          if (repeat_on_err && !locked) exp_cur = '0;
          else if (repeat_on_err && err_flag) exp_cur = lastm[curch];
          else exp_cur = stagedm[curch];
          lastm[curch] = exp_cur;
          tag_cur = tag(slotidx);
        end
        acc = {acc[30:0], d};
        nbits++;
        if (started && nbits == 16) begin
          in_valid = 1'b1;
          in_right = curch[0];
          in_data = ~dval(slotidx);
          stagedm[curch] = ~dval(slotidx);
          mid_s = slotidx;
          apply_sched(slotidx + 1);
          wphase = 1;
        end
      end
      bprev = b;
      dprev = d;

      if (!ms) begin
        if (ph == 0) begin
          bclk_in = !fl;
          fsync_in = (sb < 32);
          sb = (sb + 1) % 64;
        end else if (ph == 4) begin
          bclk_in = fl;
        end
        ph = (ph + 1) % 8;
      end
    end

    check(cyc < 20000, "R2", "run completed all slots", cyc, 20000);
    if (ms) begin
      check(first_rise == 2, "R1", "first bclk rise after run", first_rise, 2);
      check(per_err == 0, "R1", "bclk period errors", per_err, 0);
      check(edge_err == 0, "R4", "sdata off launch edge", edge_err, 0);
      check(oe_err == 0, "R1", "oe low in master", oe_err, 0);
    end else begin
      check(oe_err == 0, "R3", "oe high in slave", oe_err, 0);
    end
    run = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; master = 1'b1; fall_launch = 1'b1;
    repeat_on_err = 1'b0; in_data = '0; in_valid = 1'b0; in_right = 1'b0;
    err_flag = 1'b0; locked = 1'b1; bclk_in = 1'b0; fsync_in = 1'b0;
    repeat (3) @(negedge clk);
    check(!sdata && !bclk_oe && !fsync_oe, "R10", "reset state",
          {sdata, bclk_oe, fsync_oe}, 0);
    rst_n = 1'b1;
    for (int m = 1; m >= 0; m--) begin
      for (int e = 0; e < 2; e++) begin
        run_config(m[0], e[0]);
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule